// File: doc/BRIEF.md
# Exception Entry Controller

This block sequences how a small 32-bit processor enters and leaves an exception handler. When an exception request arrives, the block does three things in one clock. It saves the current program counter into a return-address register. It updates the interrupt-enable status bits. It produces the handler address as a new program counter. The core around it owns instruction decode, the register file and the pipeline. It presents requests and return strobes, and it applies the resulting PC load and register writeback.

There are two classes of exception. Normal exceptions save the PC in the exception-address register and the enable bit in the exception-saved enable. Debug exceptions use their own break-address register and their own saved-enable bit. Normal exceptions vector from the exception base unless the remap control is set, in which case they use the debug base. Debug exceptions always use the debug base. Each handler slot is 32 bytes wide, and each base is aligned to 256 bytes. A type code that is not valid on the port where it arrives raises an error strobe and leaves the processor state unchanged. Two return strobes restore the enable bit and reload the PC from the matching saved address.

Top module: `trap_entry_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, all of these read zero: pcLoad, wbEn, excErr, intEn, savedEn, dbgSavedEn, pcNext and wbData.
- R2: The normal port accepts 3-bit type codes 2 (instruction bus error), 4 (data bus error), 5 (divide by zero), 6 (interrupt) and 7 (system call). One cycle after an accepted request, wbEn=1, wbSel=0 (the exception-address register) and wbData is the PC sampled with the request.
- R3: A normal entry copies intEn into savedEn and clears intEn. It leaves dbgSavedEn unchanged.
- R4: The entry vector is {base page (the upper 24 bits), type code, 5'b00000}. pcLoad pulses high for exactly the cycle after the request.
- R5: When remapEn=1, a normal entry takes its vector from the debug base page instead of the exception base page.
- R6: The debug port accepts type codes 1 (breakpoint) and 3 (watchpoint). An accepted request writes back with wbSel=1 (break-address register), copies intEn into dbgSavedEn, clears intEn and keeps savedEn. It vectors from the debug base page whatever the value of remapEn.
- R7: A code that is not valid on its port sets excErr for one cycle. This covers 0, 1 and 3 on the normal port, and anything other than 1 or 3 on the debug port. pcLoad and wbEn stay low, and none of the three enable bits changes.
- R8: If both ports request in the same cycle, the debug request is handled and the normal request is dropped.
- R9: A normal return, with no request pending, sets intEn from savedEn and loads pcNext with the saved exception address. wbEn stays low.
- R10: A debug return, with no request pending, sets intEn from dbgSavedEn and loads pcNext with the saved break address. It takes precedence over a normal return in the same cycle.
- R11: An enable write loads {dbgSavedEn, savedEn, intEn} from ieWrData[2:0]. The write is ignored in any cycle that has an exception request or a return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| normReq | input | 1 | Normal exception request |
| normType | input | 3 | Normal exception type code |
| dbgReq | input | 1 | Debug exception request |
| dbgType | input | 3 | Debug exception type code |
| curPc | input | 32 | PC of the excepting instruction |
| excBasePage | input | 24 | Exception base address, upper 24 bits |
| dbgBasePage | input | 24 | Debug base address, upper 24 bits |
| remapEn | input | 1 | Send normal exceptions to the debug base |
| retNorm | input | 1 | Return from a normal exception |
| retDbg | input | 1 | Return from a debug exception |
| ieWrEn | input | 1 | Enable-bit write strobe |
| ieWrData | input | 3 | {dbgSavedEn, savedEn, intEn} write value |
| pcLoad | output | 1 | Load pcNext into the PC |
| pcNext | output | 32 | New program counter |
| wbEn | output | 1 | Return-address writeback strobe |
| wbSel | output | 1 | Writeback target: 0 exception address, 1 break address |
| wbData | output | 32 | Return address to write |
| intEn | output | 1 | Global interrupt enable |
| savedEn | output | 1 | Enable saved by a normal entry |
| dbgSavedEn | output | 1 | Enable saved by a debug entry |
| excErr | output | 1 | Unsupported type strobe |

## Verification
Two pairs of operations can land in the same cycle. The first pair is a debug request and a normal request. The bench drives both ports on one clock edge and expects only the debug side: a break-address writeback and a debug-base vector carrying the debug type code. The normal request must leave no trace in savedEn. The second pair is an enable write and an exception entry. The bench raises both together and checks on the enable outputs that the entry's update is the one that sticks.

// File: rtl/trap_pkg.sv
package trap_pkg;

  localparam int TYPE_W = 3;

  typedef enum logic [TYPE_W-1:0] {
    EXC_RESET = 3'd0,
    EXC_BREAK = 3'd1,
    EXC_IBUS  = 3'd2,
    EXC_WATCH = 3'd3,
    EXC_DBUS  = 3'd4,
    EXC_DIVZ  = 3'd5,
    EXC_IRQ   = 3'd6,
    EXC_SCALL = 3'd7
  } excCode_e;

  // strobes from control to datapath; at most one action bit is set
  typedef struct packed {
    logic              takeNorm;
    logic              takeDbg;
    logic              doRetNorm;
    logic              doRetDbg;
    logic              doIeWr;
    logic              raiseErr;
    logic              useDbgBase;
    logic [TYPE_W-1:0] vecIdx;
  } trapCtl_t;

  function automatic logic isDbgCode(input logic [TYPE_W-1:0] code);
    return (code == EXC_BREAK) || (code == EXC_WATCH);
  endfunction

  function automatic logic isNormCode(input logic [TYPE_W-1:0] code);
    return (code == EXC_IBUS) || (code == EXC_DBUS) || (code == EXC_DIVZ) ||
           (code == EXC_IRQ)  || (code == EXC_SCALL);
  endfunction

endpackage

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              normReq,
  input  logic [TYPE_W-1:0] normType,
  input  logic              dbgReq,
  input  logic [TYPE_W-1:0] dbgType,
  input  logic              remapEn,
  input  logic              retNorm,
  input  logic              retDbg,
  input  logic              ieWrEn,
  output trapCtl_t          ctl
);

  // priority: debug request, normal request, debug return, normal return, enable write
  always_comb begin
    ctl = '0;
    if (dbgReq) begin
      if (isDbgCode(dbgType)) begin
        ctl.takeDbg    = 1'b1;
        ctl.useDbgBase = 1'b1;
        ctl.vecIdx     = dbgType;
      end else begin
        ctl.raiseErr = 1'b1;
      end
    end else if (normReq) begin
      if (isNormCode(normType)) begin
        ctl.takeNorm   = 1'b1;
        ctl.useDbgBase = remapEn;
        ctl.vecIdx     = normType;
      end else begin
        ctl.raiseErr = 1'b1;
      end
    end else if (retDbg) begin
      ctl.doRetDbg = 1'b1;
    end else if (retNorm) begin
      ctl.doRetNorm = 1'b1;
    end else if (ieWrEn) begin
      ctl.doIeWr = 1'b1;
    end
  end

  AST_SINGLE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.takeNorm, ctl.takeDbg, ctl.doRetNorm, ctl.doRetDbg, ctl.doIeWr, ctl.raiseErr})); // R8

  AST_WRITE_YIELDS: assert property (@(posedge clk) disable iff (!rstN)
    (ieWrEn && (normReq || dbgReq || retNorm || retDbg)) |-> !ctl.doIeWr); // R11

endmodule

// File: rtl/trap_dpath.sv
module trap_dpath
  import trap_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int SLOT_SHIFT = 5,
  localparam int PAGE_W    = XLEN - TYPE_W - SLOT_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  trapCtl_t          ctl,
  input  logic [XLEN-1:0]   curPc,
  input  logic [PAGE_W-1:0] excBasePage,
  input  logic [PAGE_W-1:0] dbgBasePage,
  input  logic [2:0]        ieWrData,
  output logic              pcLoad,
  output logic [XLEN-1:0]   pcNext,
  output logic              wbEn,
  output logic              wbSel,
  output logic [XLEN-1:0]   wbData,
  output logic              intEn,
  output logic              savedEn,
  output logic              dbgSavedEn,
  output logic              excErr
);

  logic [XLEN-1:0]   eaQ, baQ;
  logic [XLEN-1:0]   vecAddr;
  logic [PAGE_W-1:0] selPage;
  logic              enterAny;

  assign enterAny = ctl.takeNorm | ctl.takeDbg;
  assign selPage  = ctl.useDbgBase ? dbgBasePage : excBasePage;
  assign vecAddr  = {selPage, ctl.vecIdx, {SLOT_SHIFT{1'b0}}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcLoad     <= 1'b0;
      pcNext     <= '0;
      wbEn       <= 1'b0;
      wbSel      <= 1'b0;
      wbData     <= '0;
      intEn      <= 1'b0;
      savedEn    <= 1'b0;
      dbgSavedEn <= 1'b0;
      excErr     <= 1'b0;
      eaQ        <= '0;
      baQ        <= '0;
    end else begin
      pcLoad <= enterAny | ctl.doRetNorm | ctl.doRetDbg;
      wbEn   <= enterAny;
      excErr <= ctl.raiseErr;
      if (enterAny) begin
        pcNext <= vecAddr;
        wbSel  <= ctl.takeDbg;
        wbData <= curPc;
      end else if (ctl.doRetDbg) begin
        pcNext <= baQ;
      end else if (ctl.doRetNorm) begin
        pcNext <= eaQ;
      end
      if (ctl.takeNorm) begin
        eaQ     <= curPc;
        savedEn <= intEn;
        intEn   <= 1'b0;
      end
      if (ctl.takeDbg) begin
        baQ        <= curPc;
        dbgSavedEn <= intEn;
        intEn      <= 1'b0;
      end
      if (ctl.doRetNorm) intEn <= savedEn;
      if (ctl.doRetDbg)  intEn <= dbgSavedEn;
      if (ctl.doIeWr) {dbgSavedEn, savedEn, intEn} <= ieWrData;
    end
  end

  AST_ERR_NO_REDIRECT: assert property (@(posedge clk) disable iff (!rstN)
    excErr |-> (!pcLoad && !wbEn)); // R7

  AST_ENTRY_CLEARS_IE: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> !intEn); // R3

  AST_WB_IS_PC: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> (wbData == $past(curPc))); // R2

  AST_VEC_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> (pcLoad && pcNext[SLOT_SHIFT-1:0] == '0)); // R4

  AST_DBG_KEEPS_EIE: assert property (@(posedge clk) disable iff (!rstN)
    (wbEn && wbSel) |-> (savedEn == $past(savedEn))); // R6

  AST_RET_RESTORE: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.doRetNorm) |-> (intEn == $past(savedEn) && !wbEn)); // R9

  AST_RET_DBG_PC: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.doRetDbg) |-> (pcNext == $past(baQ) && intEn == $past(dbgSavedEn))); // R10

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int SLOT_SHIFT = 5,
  localparam int PAGE_W    = XLEN - TYPE_W - SLOT_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              normReq,
  input  logic [TYPE_W-1:0] normType,
  input  logic              dbgReq,
  input  logic [TYPE_W-1:0] dbgType,
  input  logic [XLEN-1:0]   curPc,
  input  logic [PAGE_W-1:0] excBasePage,
  input  logic [PAGE_W-1:0] dbgBasePage,
  input  logic              remapEn,
  input  logic              retNorm,
  input  logic              retDbg,
  input  logic              ieWrEn,
  input  logic [2:0]        ieWrData,
  output logic              pcLoad,
  output logic [XLEN-1:0]   pcNext,
  output logic              wbEn,
  output logic              wbSel,
  output logic [XLEN-1:0]   wbData,
  output logic              intEn,
  output logic              savedEn,
  output logic              dbgSavedEn,
  output logic              excErr
);

  trapCtl_t ctl;

  trap_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .normReq  (normReq),
    .normType (normType),
    .dbgReq   (dbgReq),
    .dbgType  (dbgType),
    .remapEn  (remapEn),
    .retNorm  (retNorm),
    .retDbg   (retDbg),
    .ieWrEn   (ieWrEn),
    .ctl      (ctl)
  );

  trap_dpath #(
    .XLEN       (XLEN),
    .SLOT_SHIFT (SLOT_SHIFT)
  ) dpath_i (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .curPc       (curPc),
    .excBasePage (excBasePage),
    .dbgBasePage (dbgBasePage),
    .ieWrData    (ieWrData),
    .pcLoad      (pcLoad),
    .pcNext      (pcNext),
    .wbEn        (wbEn),
    .wbSel       (wbSel),
    .wbData      (wbData),
    .intEn       (intEn),
    .savedEn     (savedEn),
    .dbgSavedEn  (dbgSavedEn),
    .excErr      (excErr)
  );

  AST_DBG_PRIORITY: assert property (@(posedge clk) disable iff (!rstN)
    $past(dbgReq && normReq && isDbgCode(dbgType)) |-> (wbEn && wbSel)); // R8

  AST_REMAP_VEC: assert property (@(posedge clk) disable iff (!rstN)
    (wbEn && !wbSel && $past(remapEn)) |-> (pcNext[XLEN-1:XLEN-PAGE_W] == $past(dbgBasePage))); // R5

  AST_DBG_BASE_ALWAYS: assert property (@(posedge clk) disable iff (!rstN)
    (wbEn && wbSel) |-> (pcNext[XLEN-1:XLEN-PAGE_W] == $past(dbgBasePage))); // R6

endmodule

// File: tb/trap_entry_unit_tb_top.sv
`timescale 1ns/1ps
module trap_entry_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        normReq = 1'b0;
  logic [2:0]  normType = 3'd0;
  logic        dbgReq = 1'b0;
  logic [2:0]  dbgType = 3'd0;
  logic [31:0] curPc = 32'd0;
  logic [23:0] excBasePage = 24'h123456;
  logic [23:0] dbgBasePage = 24'hABCDEF;
  logic        remapEn = 1'b0;
  logic        retNorm = 1'b0;
  logic        retDbg = 1'b0;
  logic        ieWrEn = 1'b0;
  logic [2:0]  ieWrData = 3'd0;
  logic        pcLoad, wbEn, wbSel, intEn, savedEn, dbgSavedEn, excErr;
  logic [31:0] pcNext, wbData;

  always #5 clk = ~clk;

  trap_entry_unit dut_i (
    .clk(clk), .rstN(rstN), .normReq(normReq), .normType(normType),
    .dbgReq(dbgReq), .dbgType(dbgType), .curPc(curPc),
    .excBasePage(excBasePage), .dbgBasePage(dbgBasePage), .remapEn(remapEn),
    .retNorm(retNorm), .retDbg(retDbg), .ieWrEn(ieWrEn), .ieWrData(ieWrData),
    .pcLoad(pcLoad), .pcNext(pcNext), .wbEn(wbEn), .wbSel(wbSel),
    .wbData(wbData), .intEn(intEn), .savedEn(savedEn),
    .dbgSavedEn(dbgSavedEn), .excErr(excErr)
  );

  typedef struct {
    bit          pcLoad;
    logic [31:0] pcNext;
    bit          wbEn;
    bit          wbSel;
    logic [31:0] wbData;
    bit          ie, eie, bie, err;
    string       req;
  } expItem_t;

  expItem_t expQ[$];
  int  checks = 0;
  int  failures = 0;
  bit  finished = 0;

  // reference state, kept from the requirements
  bit          mIe = 0, mEie = 0, mBie = 0;
  logic [31:0] mEa = 0, mBa = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // driver: applies one cycle of stimulus and queues the expected outcome
  task automatic step(input bit nR, input logic [2:0] nT, input bit dR, input logic [2:0] dT,
                      input logic [31:0] pc, input bit remap, input bit rN, input bit rD,
                      input bit iw, input logic [2:0] iwd, input string req);
    expItem_t e;
    @(negedge clk);
    normReq = nR; normType = nT; dbgReq = dR; dbgType = dT; curPc = pc;
    remapEn = remap; retNorm = rN; retDbg = rD; ieWrEn = iw; ieWrData = iwd;
    e.pcLoad = 0; e.pcNext = 0; e.wbEn = 0; e.wbSel = 0; e.wbData = 0; e.err = 0; e.req = req;
    if (dR) begin
      if (dT == 3'd1 || dT == 3'd3) begin
        e.pcLoad = 1; e.wbEn = 1; e.wbSel = 1; e.wbData = pc;
        e.pcNext = {dbgBasePage, dT, 5'b0};
        mBa = pc; mBie = mIe; mIe = 0;
      end else e.err = 1;
    end else if (nR) begin
      if (nT == 3'd2 || nT >= 3'd4) begin
        e.pcLoad = 1; e.wbEn = 1; e.wbSel = 0; e.wbData = pc;
        e.pcNext = {(remap ? dbgBasePage : excBasePage), nT, 5'b0};
        mEa = pc; mEie = mIe; mIe = 0;
      end else e.err = 1;
    end else if (rD) begin
      e.pcLoad = 1; e.pcNext = mBa; mIe = mBie;
    end else if (rN) begin
      e.pcLoad = 1; e.pcNext = mEa; mIe = mEie;
    end else if (iw) begin
      {mBie, mEie, mIe} = iwd;
    end
    e.ie = mIe; e.eie = mEie; e.bie = mBie;
    expQ.push_back(e);
  endtask

  task automatic idle(input string req);
    step(0, 3'd0, 0, 3'd0, 32'h0, 0, 0, 0, 0, 3'd0, req);
  endtask

  // monitor: compares each result just after the edge that produces it
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        chk(pcLoad == e.pcLoad, e.req, "pcLoad", 32'(pcLoad), 32'(e.pcLoad));
        chk(wbEn == e.wbEn, e.req, "wbEn", 32'(wbEn), 32'(e.wbEn));
        chk(excErr == e.err, e.req, "excErr", 32'(excErr), 32'(e.err));
        chk({dbgSavedEn, savedEn, intEn} == {e.bie, e.eie, e.ie}, e.req, "enables",
            32'({dbgSavedEn, savedEn, intEn}), 32'({e.bie, e.eie, e.ie}));
        if (e.pcLoad) chk(pcNext == e.pcNext, e.req, "pcNext", pcNext, e.pcNext);
        if (e.wbEn) begin
          chk(wbSel == e.wbSel, e.req, "wbSel", 32'(wbSel), 32'(e.wbSel));
          chk(wbData == e.wbData, e.req, "wbData", wbData, e.wbData);
        end
      end
    end
  end

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog run did not complete actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset values
    chk({pcLoad, wbEn, excErr, intEn, savedEn, dbgSavedEn} == 6'b0, "R1", "flags",
        32'({pcLoad, wbEn, excErr, intEn, savedEn, dbgSavedEn}), 32'h0);
    chk(pcNext == 32'h0 && wbData == 32'h0, "R1", "pcNext|wbData", pcNext | wbData, 32'h0);
    rstN = 1'b1;
    idle("R1");
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 3'b001, "R11");            // set intEn
    step(1, 3'd6, 0, 0, 32'h0000_1000, 0, 0, 0, 0, 0, "R2_R3_R4");
    step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R9");                   // normal return
    step(1, 3'd2, 0, 0, 32'h0000_2000, 1, 0, 0, 0, 0, "R5");    // remapped
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 3'b001, "R11");
    step(0, 0, 1, 3'd1, 32'h0000_3000, 1, 0, 0, 0, 0, "R6");    // remap ignored
    step(0, 0, 0, 0, 0, 0, 1, 1, 0, 0, "R10");                  // debug return wins
    step(1, 3'd0, 0, 0, 32'h0000_4000, 0, 0, 0, 0, 0, "R7");
    step(1, 3'd3, 0, 0, 32'h0000_4004, 0, 0, 0, 0, 0, "R7");
    step(0, 0, 1, 3'd5, 32'h0000_4008, 0, 0, 0, 0, 0, "R7");
    step(1, 3'd1, 0, 0, 32'h0000_400C, 0, 0, 0, 0, 0, "R7");
    step(1, 3'd5, 1, 3'd3, 32'h0000_5000, 0, 0, 0, 0, 0, "R8"); // both ports
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 3'b011, "R11");
    step(1, 3'd4, 0, 0, 32'h0000_6000, 0, 0, 0, 1, 3'b111, "R11"); // write ignored
    step(1, 3'd7, 0, 0, 32'h0000_7000, 0, 0, 0, 0, 0, "R3");    // intEn 0 copied
    step(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R10");
    step(0, 0, 0, 0, 0, 0, 1, 0, 1, 3'b110, "R11");             // return beats write
    step(1, 3'd5, 0, 0, 32'h0000_8000, 0, 0, 0, 0, 0, "R4");
    idle("R4");
    idle("R7");
    @(negedge clk);
    @(negedge clk);
    summary();
  end

endmodule